// File: doc/BRIEF.md
# Hardware Loop Instruction Cache

This block sits between the instruction memory port and the issue stage of a small processor core. It lets the core run a short loop body repeatedly without fetching it again. A loop request supplies the body length in words and the number of passes. During the first pass, every word fetched from instruction memory is forwarded straight to issue and written into a 15-entry buffer in the same cycle. Every later pass issues the body from that buffer. While the buffer is replaying, the block marks the instruction memory bus as free, so the core can use the bus for data reads.

The issue stage controls the pace with an advance input. A word is consumed at a rising clock edge only when advance is high. When advance is low, the current word and the loop position are held. After the last word of the final pass is consumed, the block raises a one-cycle completion pulse and returns to forwarding the memory stream.

Top module: `loop_cache`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_free_o`, `loop_done_o` and `len_err_o` are 0, and `issue_word_o` equals `fetch_word_i`.
- R2: When no loop is active, `issue_word_o` follows `fetch_word_i` combinationally and `bus_free_o` is 0.
- R3: A request with `loop_start_i`=1 while idle is rejected when `loop_len_i` is 0, `loop_len_i` is greater than 15, or `loop_cnt_i` is 0. A rejected request pulses `len_err_o` high in the following cycle, starts no loop, leaves `bus_free_o` at 0 and raises no `loop_done_o`.
- R4: In the first pass, the k-th consumed word (k = 0 to len-1) is issued directly from `fetch_word_i` and captured, with `bus_free_o` = 0.
- R5: In passes 2 to N, word k of the body is issued from the buffer in the same order as captured, whatever `fetch_word_i` holds, with `bus_free_o` = 1.
- R6: With `loop_cnt_i` = 1, the body runs once from memory, `bus_free_o` never rises, and the loop ends after len consumed words.
- R7: `loop_done_o` is high for exactly one cycle, the cycle after the edge that consumes the last word of the final pass. In that cycle `bus_free_o` is 0 and `issue_word_o` again follows `fetch_word_i`.
- R8: While `advance_i` is 0, the issued word and the loop position do not change.
- R9: `loop_start_i` is ignored while a loop is active.
- R10: A body of the maximum length, 15 words, is captured and replayed in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loop_start_i | input | 1 | Loop request strobe, sampled while idle |
| loop_len_i | input | 5 | Body length in words (valid range 1 to 15) |
| loop_cnt_i | input | 8 | Number of passes (must be at least 1) |
| fetch_word_i | input | 16 | Word read from instruction memory |
| advance_i | input | 1 | Issue stage consumes the current word at this edge |
| issue_word_o | output | 16 | Word presented to the issue stage |
| bus_free_o | output | 1 | Instruction bus is not needed (replay in progress) |
| loop_done_o | output | 1 | One-cycle pulse after the final word of the loop |
| len_err_o | output | 1 | One-cycle pulse after a rejected loop request |

## Verification
The hardest states to reach are stalls on the edges between passes. These include advance dropping on the last word of the fill pass and on the wrap from the last buffer entry back to entry 0. In those cases an early switch of source, or a double decrement of the pass counter, would show up only as a single misplaced word. The bench sweeps every legal length against several pass counts. It repeats each sweep with advance held low on every third cycle, so these boundaries land in stalled cycles for many length and phase combinations. During replay, memory is driven with a changing garbage value, so any word taken from the bus instead of the buffer shows up as a mismatch.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    LC_IDLE   = 2'd0,
    LC_FILL   = 2'd1,
    LC_REPLAY = 2'd2
  } lc_state_e;
endpackage

// File: rtl/lc_check.sv
// Validates a loop request against the buffer depth.
module lc_check #(
  parameter int DEPTH = 15,
  parameter int LEN_W = 5,
  parameter int CNT_W = 8
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             ok_o
);
  localparam logic [LEN_W-1:0] MaxLen = LEN_W'(DEPTH);

  always_comb begin
    ok_o = (len_i != '0) && (len_i <= MaxLen) && (cnt_i != '0);
  end
endmodule

// File: rtl/lc_store.sv
// Loop body storage: one register per entry, combinational read.
module lc_store #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 15,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= '0;
      end else if (we_i && (widx_i == IDX_W'(g))) begin
        ent_q[g] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ridx_i == IDX_W'(i)) rdata_o = ent_q[i];
    end
  end
endmodule

// File: rtl/lc_seq.sv
// Loop sequencer: fill pass, replay passes, completion.
module lc_seq
  import lc_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int CNT_W = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ok_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             adv_i,
  output lc_state_e        state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             we_o,
  output logic             done_o,
  output logic             err_o
);
  lc_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] rem_q;
  logic             done_q, err_q;
  logic             last_word;

  always_comb begin
    last_word = ((LEN_W'(idx_q) + LEN_W'(1)) == len_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LC_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        LC_IDLE: begin
          if (start_i) begin
            if (ok_i) begin
              state_q <= LC_FILL;
              len_q   <= len_i;
              rem_q   <= cnt_i;
              idx_q   <= '0;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        LC_FILL, LC_REPLAY: begin
          if (adv_i) begin
            if (last_word) begin
              idx_q <= '0;
              if (rem_q == CNT_W'(1)) begin
                state_q <= LC_IDLE;
                done_q  <= 1'b1;
              end else begin
                rem_q   <= rem_q - CNT_W'(1);
                state_q <= LC_REPLAY;
              end
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        default: state_q <= LC_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign we_o    = (state_q == LC_FILL) && adv_i;
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/loop_cache.sv
module loop_cache
  import lc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 15,
  parameter int CNT_W  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              loop_start_i,
  input  logic [LEN_W-1:0]  loop_len_i,
  input  logic [CNT_W-1:0]  loop_cnt_i,
  input  logic [WORD_W-1:0] fetch_word_i,
  input  logic              advance_i,
  output logic [WORD_W-1:0] issue_word_o,
  output logic              bus_free_o,
  output logic              loop_done_o,
  output logic              len_err_o
);
  lc_state_e         state;
  logic [IDX_W-1:0]  idx;
  logic              we;
  logic              req_ok;
  logic              busy;
  logic [WORD_W-1:0] cache_word;

  lc_check #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_check (
    .len_i (loop_len_i),
    .cnt_i (loop_cnt_i),
    .ok_o  (req_ok)
  );

  lc_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (loop_start_i),
    .ok_i    (req_ok),
    .len_i   (loop_len_i),
    .cnt_i   (loop_cnt_i),
    .adv_i   (advance_i),
    .state_o (state),
    .idx_o   (idx),
    .we_o    (we),
    .done_o  (loop_done_o),
    .err_o   (len_err_o)
  );

  lc_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .widx_i  (idx),
    .wdata_i (fetch_word_i),
    .ridx_i  (idx),
    .rdata_o (cache_word)
  );

  always_comb begin
    busy         = (state != LC_IDLE);
    bus_free_o   = (state == LC_REPLAY);
    issue_word_o = bus_free_o ? cache_word : fetch_word_i;
  end
endmodule

// File: rtl/lc_sva.sv
module lc_sva #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 15,
  parameter int CNT_W  = 8,
  parameter int LEN_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              loop_start_i,
  input logic [LEN_W-1:0]  loop_len_i,
  input logic [CNT_W-1:0]  loop_cnt_i,
  input logic              advance_i,
  input logic [WORD_W-1:0] issue_word_o,
  input logic              bus_free_o,
  input logic              loop_done_o,
  input logic              len_err_o,
  input logic              busy_i
);
  logic bad_req;
  always_comb begin
    bad_req = (loop_len_i == '0) || (int'(loop_len_i) > DEPTH) || (loop_cnt_i == '0);
  end

  AST_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_start_i && !busy_i && bad_req) |=> (len_err_o && !busy_i && !loop_done_o)); // R3
  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_start_i && !busy_i && !bad_req) |=> (busy_i && !len_err_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_done_o |=> !loop_done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_done_o |-> (!bus_free_o && !busy_i)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_free_o && !advance_i) |=> (bus_free_o && $stable(issue_word_o))); // R8
  AST_FREE_IN_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_free_o |-> busy_i); // R5
  AST_BUSY_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !len_err_o); // R9
endmodule

bind loop_cache lc_sva #(
  .WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)
) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .loop_start_i (loop_start_i),
  .loop_len_i   (loop_len_i),
  .loop_cnt_i   (loop_cnt_i),
  .advance_i    (advance_i),
  .issue_word_o (issue_word_o),
  .bus_free_o   (bus_free_o),
  .loop_done_o  (loop_done_o),
  .len_err_o    (len_err_o),
  .busy_i       (busy)
);

// File: tb/loop_cache_tb.sv
`timescale 1ns/1ps
module loop_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  len_in = '0;
  logic [7:0]  cnt_in = '0;
  logic [15:0] fetch = '0;
  logic        adv = 1'b0;
  logic [15:0] issue;
  logic        bus_free, done, err;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  loop_cache u_dut (
    .clk_i(clk), .rst_ni(rst_n), .loop_start_i(start), .loop_len_i(len_in),
    .loop_cnt_i(cnt_in), .fetch_word_i(fetch), .advance_i(adv),
    .issue_word_o(issue), .bus_free_o(bus_free), .loop_done_o(done),
    .len_err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_loop(input int len, input int cnt, input int stall, input int poke);
    int base, n, cyc, total;
    string tg;
    bit prev_stall;
    base  = ((len & 15) << 12) | ((cnt & 15) << 8) | ((stall & 1) << 4);
    total = len * cnt;
    @(negedge clk);
    start = 1'b1; len_in = 5'(len); cnt_in = 8'(cnt); adv = 1'b0; fetch = 16'hBEEF;
    #1;
    chk(issue == 16'hBEEF, "R2 idle passthrough", issue, 16'hBEEF);
    chk(!bus_free, "R2 idle bus", bus_free, 0);
    @(negedge clk);
    start = 1'b0;
    n = 0; cyc = 0; prev_stall = 1'b0;
    while (n < total) begin
      adv   = (stall != 0 && (cyc % 3) == 1) ? 1'b0 : 1'b1;
      fetch = (n < len) ? 16'(base + n) : 16'(16'hDEAD ^ 16'(cyc));
      start = (poke != 0 && n == len) ? 1'b1 : 1'b0;
      if (start) begin len_in = 5'd3; cnt_in = 8'd2; end
      #1;
      if (prev_stall) tg = "R8 stall hold";
      else if (len == 15) tg = "R10 max body";
      else if (cnt == 1) tg = "R6 single pass";
      else if (n < len) tg = "R4 fill";
      else tg = "R5 replay";
      chk(issue == 16'(base + (n % len)), tg, issue, base + (n % len));
      chk(bus_free == (n >= len), tg, bus_free, int'(n >= len));
      chk(!done, "R7 no early done", done, 0);
      if (poke != 0) chk(!err, "R9 start ignored", err, 0);
      prev_stall = !adv;
      if (adv) n++;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; adv = 1'b0; fetch = 16'h5A5A;
    #1;
    chk(done, "R7 done pulse", done, 1);
    chk(!bus_free, "R7 bus after done", bus_free, 0);
    chk(issue == 16'h5A5A, "R7 passthrough after done", issue, 16'h5A5A);
    @(negedge clk);
    #1;
    chk(!done, "R7 done width", done, 0);
    chk(!bus_free, "R7 stays idle", bus_free, 0);
  endtask

  task automatic run_err(input int len, input int cnt);
    @(negedge clk);
    start = 1'b1; len_in = 5'(len); cnt_in = 8'(cnt); adv = 1'b1; fetch = 16'h7777;
    @(negedge clk);
    start = 1'b0; fetch = 16'h8888;
    #1;
    chk(err, "R3 reject flag", err, 1);
    chk(!bus_free, "R3 no loop", bus_free, 0);
    chk(issue == 16'h8888, "R3 passthrough", issue, 16'h8888);
    @(negedge clk);
    #1;
    chk(!err, "R3 flag width", err, 0);
    chk(!bus_free && !done, "R3 no loop later", {bus_free, done}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    fetch = 16'h1234;
    repeat (3) @(negedge clk);
    #1;
    chk(!bus_free && !done && !err, "R1 reset outputs", {bus_free, done, err}, 0);
    chk(issue == 16'h1234, "R1 reset passthrough", issue, 16'h1234);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!bus_free && !done && !err, "R1 after reset", {bus_free, done, err}, 0);
    for (int st = 0; st < 2; st++)
      for (int l = 1; l <= 15; l++)
        for (int c = 1; c <= 4; c++)
          run_loop(l, c, st, 0);
    run_loop(15, 3, 0, 1);
    run_loop(6, 4, 1, 1);
    run_loop(15, 6, 1, 0);
    run_err(0, 3);
    run_err(16, 2);
    run_err(31, 1);
    run_err(5, 0);
    run_loop(4, 2, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule